// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked request interface and an external asynchronous static RAM of 64K words by 16 bits. It turns single-word writes, single-word reads and in-page burst reads into the chip-select, write-strobe, output-strobe and byte-select waveforms that the memory expects. A burst keeps the page part of the address (the upper 12 bits) and the chip selects fixed while the low 4 bits step from word to word, so the memory can keep one internal page open.

All memory timing is met by counting clock cycles. The clock period and every memory timing limit are parameters, and each wait is the limit in nanoseconds divided by the period, rounded up. After a read, at least one cycle passes with the output strobe released before the controller drives the data bus again, so the memory's drivers have time to go to high impedance. The data bus is brought out as a separate output word, input word and drive enable, which the pad ring combines into one tri-state bus.

A user raises `req_valid` with the command fields. A request is taken on a rising edge where `req_ready` is high. Each word read comes back on `rsp_rdata` with a one-cycle `rsp_valid` pulse. A burst that would leave its page is refused with a one-cycle `rsp_err` pulse.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_ce1_n` is 1, `mem_ce2` is 0, `mem_we_n`, `mem_oe_n`, `mem_ub_n` and `mem_lb_n` are 1, and `mem_dq_oe`, `rsp_valid` and `rsp_err` are 0.
- R2: A write holds `mem_we_n` low for max(ceil(T_WP_NS/CLK_PERIOD_NS), ceil(T_DW_NS/CLK_PERIOD_NS)) cycles and drives `mem_dq_oe` while the strobe is low. Mask bit 1 enables the upper byte (bits 15..8, `mem_ub_n` low) and mask bit 0 enables the lower byte (bits 7..0, `mem_lb_n` low). Bytes that are not enabled keep their old contents.
- R3: A write keeps `req_ready` low for the strobe count plus max(1, ceil(T_WC_NS/CLK_PERIOD_NS) minus the strobe count) cycles, which is 3 cycles at the defaults.
- R4: A read holds `mem_oe_n` low with `mem_we_n` high for max(ceil(T_RC), ceil(T_AA), ceil(T_OE)) cycles per word. The controller samples the bus on the edge that ends this count and then gives one `rsp_valid` pulse per word, in request order.
- R5: Read data bytes whose mask bit is 0 are returned as zero. With a mask of 00 the whole word is zero.
- R6: A burst of length L from 1 to 16 reads L words at consecutive low addresses. Bits 15..4 of `mem_addr` and both chip enables stay unchanged while `mem_oe_n` is low.
- R7: A read whose length is 0, or whose start word (bits 3..0) plus length is more than 16, gives one `rsp_err` pulse in the cycle after it is taken. It starts no memory cycle and gives no `rsp_valid`. A burst that ends exactly on word 15 is accepted.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After each read the output strobe stays released for max(1, ceil(T_HZ_NS/CLK_PERIOD_NS)) cycles before `req_ready` returns.
- R9: While `req_ready` is 0, `req_valid` and the command fields have no effect.
- R10: A write stores exactly one word, whatever the value of `req_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | A request is present |
| req_ready | output | 1 | The controller is idle and takes the request on this edge |
| req_write | input | 1 | 1 = write one word, 0 = read (single or burst) |
| req_addr | input | 16 | Word address; bits 15..4 select the page, bits 3..0 the word |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| req_len | input | 5 | Number of words to read, 1 to 16 |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_rdata` holds one word read |
| rsp_rdata | output | 16 | Read data, with disabled bytes cleared |
| rsp_err | output | 1 | One-cycle pulse: the read request was refused |
| mem_ce1_n | output | 1 | Memory chip enable, active low |
| mem_ce2 | output | 1 | Memory chip enable, active high |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output strobe, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_addr | output | 16 | Memory address |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | 1 = drive `mem_dq_o` onto the bus |
| mem_dq_i | input | 16 | Data read from the bus |

## Verification
The bench uses the default timing set with a 20 ns period. This gives 3 cycles per read word, 2 cycles of write strobe, a 3-cycle write and 1 turnaround cycle. At these values a count that is one cycle too short shows up in the bench's memory model: the model returns junk if the output strobe has been low for less than the access time, and it flags any write strobe shorter than 40 ns. A full 16-word burst, bursts that stop at the page edge or cross it, and every byte mask can all be reached, and each one ends after a few dozen cycles.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WR_LOW,
    ST_WR_REC,
    ST_TURN
  } sram_state_t;

  function automatic int unsigned ns_to_cyc(input int unsigned t_ns, input int unsigned per_ns);
    return (t_ns + per_ns - 1) / per_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_rst_sync.sv
module sram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/sram_wait_cnt.sv
module sram_wait_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_page_guard.sv
module sram_page_guard #(
  parameter int unsigned WORD_BITS = 4
) (
  input  logic [WORD_BITS-1:0] start_word,
  input  logic [WORD_BITS:0]   len,
  output logic                 refuse
);
  localparam int unsigned SUM_W      = WORD_BITS + 2;
  localparam int unsigned PAGE_WORDS = 1 << WORD_BITS;

  logic [SUM_W-1:0] end_excl;

  always_comb begin
    end_excl = SUM_W'(start_word) + SUM_W'(len);
    refuse   = (len == '0) || (end_excl > SUM_W'(PAGE_WORDS));
  end
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W        = 16,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned WORD_BITS     = 4,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_RC_NS       = 55,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_OE_NS       = 30,
  parameter int unsigned T_WP_NS       = 40,
  parameter int unsigned T_DW_NS       = 35,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_HZ_NS       = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [1:0]           req_bmask,
  input  logic [WORD_BITS:0]   req_len,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic                 rsp_err,
  output logic                 mem_ce1_n,
  output logic                 mem_ce2,
  output logic                 mem_we_n,
  output logic                 mem_oe_n,
  output logic                 mem_ub_n,
  output logic                 mem_lb_n,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_dq_o,
  output logic                 mem_dq_oe,
  input  logic [DATA_W-1:0]    mem_dq_i
);
  localparam int unsigned HALF_W  = DATA_W / 2;
  localparam int unsigned RD_CYC  = umax(umax(ns_to_cyc(T_RC_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_AA_NS, CLK_PERIOD_NS)),
                                         umax(ns_to_cyc(T_OE_NS, CLK_PERIOD_NS), 1));
  localparam int unsigned WP_CYC  = umax(umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                              ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)), 1);
  localparam int unsigned WC_CYC  = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC = (WC_CYC > WP_CYC + 1) ? (WC_CYC - WP_CYC) : 1;
  localparam int unsigned TA_CYC  = umax(ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned MAX_CYC = umax(umax(RD_CYC, WP_CYC), umax(REC_CYC, TA_CYC));
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LD  = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD  = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] TA_LD  = CNT_W'(TA_CYC - 1);

  logic                 rst_i_n;
  sram_state_t          state_q, state_d;
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [1:0]           mask_q;
  logic [WORD_BITS-1:0] remain_q, remain_d;
  logic [DATA_W-1:0]    rdata_q;
  logic                 rvalid_q, err_q, err_d;
  logic                 take, step, capture;
  logic                 cnt_load, cnt_done;
  logic [CNT_W-1:0]     cnt_val;
  logic                 refuse;
  logic [DATA_W-1:0]    keep_mask;
  logic                 active;

  sram_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  sram_wait_cnt #(.CNT_W(CNT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .done     (cnt_done)
  );

  sram_page_guard #(.WORD_BITS(WORD_BITS)) u_guard (
    .start_word (req_addr[WORD_BITS-1:0]),
    .len        (req_len),
    .refuse     (refuse)
  );

  // next-state and control decode
  always_comb begin
    state_d  = state_q;
    remain_d = remain_q;
    cnt_load = 1'b0;
    cnt_val  = '0;
    take     = 1'b0;
    step     = 1'b0;
    capture  = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_write) begin
            state_d  = ST_WR_LOW;
            take     = 1'b1;
            remain_d = '0;
            cnt_load = 1'b1;
            cnt_val  = WP_LD;
          end else if (refuse) begin
            err_d = 1'b1;
          end else begin
            state_d  = ST_RD;
            take     = 1'b1;
            remain_d = req_len[WORD_BITS-1:0] - WORD_BITS'(1);
            cnt_load = 1'b1;
            cnt_val  = RD_LD;
          end
        end
      end
      ST_RD: begin
        if (cnt_done) begin
          capture  = 1'b1;
          cnt_load = 1'b1;
          if (remain_q != '0) begin
            step     = 1'b1;
            remain_d = remain_q - WORD_BITS'(1);
            cnt_val  = RD_LD;
          end else begin
            state_d = ST_TURN;
            cnt_val = TA_LD;
          end
        end
      end
      ST_WR_LOW: begin
        if (cnt_done) begin
          state_d  = ST_WR_REC;
          cnt_load = 1'b1;
          cnt_val  = REC_LD;
        end
      end
      ST_WR_REC: if (cnt_done) state_d = ST_IDLE;
      ST_TURN:   if (cnt_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    keep_mask = {{HALF_W{mask_q[1]}}, {HALF_W{mask_q[0]}}};
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      mask_q   <= '0;
      remain_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= capture;
      err_q    <= err_d;
      if (take) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        mask_q  <= req_bmask;
      end else if (step) begin
        addr_q[WORD_BITS-1:0] <= addr_q[WORD_BITS-1:0] + WORD_BITS'(1);
      end
      if (take || step) remain_q <= remain_d;
      if (capture)      rdata_q  <= mem_dq_i & keep_mask;
    end
  end

  // memory-side and user-side outputs, decoded from registered state
  always_comb begin
    active    = (state_q == ST_RD) || (state_q == ST_WR_LOW) || (state_q == ST_WR_REC);
    mem_ce1_n = !active;
    mem_ce2   = active;
    mem_ub_n  = !(active && mask_q[1]);
    mem_lb_n  = !(active && mask_q[0]);
    mem_we_n  = (state_q != ST_WR_LOW);
    mem_oe_n  = (state_q != ST_RD);
    mem_dq_oe = (state_q == ST_WR_LOW) || (state_q == ST_WR_REC);
    mem_addr  = addr_q;
    mem_dq_o  = wdata_q;
    req_ready = (state_q == ST_IDLE);
    rsp_valid = rvalid_q;
    rsp_rdata = rdata_q;
    rsp_err   = err_q;
  end
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned PAGE_W        = 12,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_WP_NS       = 40,
  parameter int unsigned T_DW_NS       = 35
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe,
  input logic [PAGE_W-1:0] page_addr
);
  localparam int unsigned WP_MIN = umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                        ns_to_cyc(T_DW_NS, CLK_PERIOD_NS));
  localparam int unsigned LC_W   = $clog2(WP_MIN + 2) + 1;

  logic [LC_W-1:0] we_lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                      we_lo_cnt <= '0;
    else if (mem_we_n)                               we_lo_cnt <= '0;
    else if (we_lo_cnt != {LC_W{1'b1}})              we_lo_cnt <= we_lo_cnt + LC_W'(1);
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r2_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_lo_cnt >= LC_W'(WP_MIN)));

  a_r4_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  a_r6_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n && !$past(mem_oe_n)) |-> ($stable(page_addr) && $stable(mem_ce1_n) && $stable(mem_ce2)));

  a_r7_refuse_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (mem_ce1_n && !mem_ce2 && !rsp_valid));

  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  a_r8_turn_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |-> (!mem_dq_oe && !req_ready));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .PAGE_W        (ADDR_W - WORD_BITS),
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .T_WP_NS       (T_WP_NS),
  .T_DW_NS       (T_DW_NS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n),
  .mem_dq_oe (mem_dq_oe),
  .page_addr (mem_addr[ADDR_W-1:WORD_BITS])
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb;
  localparam int P      = 20;
  localparam int T_RC   = 55;
  localparam int T_AA   = 55;
  localparam int T_OE   = 30;
  localparam int T_WP   = 40;
  localparam int T_DW   = 35;
  localparam int T_WC   = 55;
  localparam int T_HZ   = 20;
  localparam int RD_N   = (T_RC + P - 1) / P;
  localparam int WP_N   = (T_WP + P - 1) / P;
  localparam int WC_N   = (T_WC + P - 1) / P;
  localparam int WR_N   = WP_N + ((WC_N - WP_N > 1) ? (WC_N - WP_N) : 1);
  localparam int TA_N   = ((T_HZ + P - 1) / P > 1) ? (T_HZ + P - 1) / P : 1;
  localparam int AA_N   = (T_AA + P - 1) / P;

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [15:0] req_addr, req_wdata;
  logic [1:0]  req_bmask;
  logic [4:0]  req_len;
  logic        rsp_valid, rsp_err;
  logic [15:0] rsp_rdata;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_addr, mem_dq_o, mem_dq_i;

  int n_chk = 0;
  int n_err = 0;
  int proto_err = 0;

  sram_async_ctrl #(
    .CLK_PERIOD_NS(P), .T_RC_NS(T_RC), .T_AA_NS(T_AA), .T_OE_NS(T_OE),
    .T_WP_NS(T_WP), .T_DW_NS(T_DW), .T_WC_NS(T_WC), .T_HZ_NS(T_HZ)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural memory model, updated away from the active edge
  logic [15:0] mem_m [int];
  logic [15:0] shadow [int];
  logic [15:0] prev_addr;
  logic        prev_rd;
  logic        m_sel, m_rd;
  logic [15:0] m_word;
  int          rd_ticks, we_lo;

  initial begin
    prev_addr = '0; prev_rd = 1'b0; rd_ticks = 0; we_lo = 0; mem_dq_i = 16'hBAD0;
  end

  always @(negedge clk) begin
    m_sel = (mem_ce1_n === 1'b0) && (mem_ce2 === 1'b1) && !(mem_ub_n && mem_lb_n);
    m_rd  = m_sel && (mem_we_n === 1'b1) && (mem_oe_n === 1'b0);
    if (m_rd && mem_dq_oe) proto_err++;
    if (m_rd && prev_rd && (mem_addr == prev_addr)) rd_ticks++;
    else rd_ticks = m_rd ? 1 : 0;
    m_word = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 16'h0000;
    if (m_rd && rd_ticks >= AA_N)
      mem_dq_i <= {mem_ub_n ? 8'hA5 : m_word[15:8], mem_lb_n ? 8'hA5 : m_word[7:0]};
    else
      mem_dq_i <= 16'hBAD0;
    if (mem_we_n === 1'b0) begin
      we_lo++;
    end else if (we_lo > 0) begin
      check((we_lo * P >= T_WP) && mem_dq_oe, "R2", "write strobe ns / data driven",
            we_lo * P, T_WP);
      if (m_sel) begin
        if (!mem_ub_n) m_word[15:8] = mem_dq_o[15:8];
        if (!mem_lb_n) m_word[7:0]  = mem_dq_o[7:0];
        mem_m[int'(mem_addr)] = m_word;
      end
      we_lo = 0;
    end
    prev_addr = mem_addr;
    prev_rd   = m_rd;
  end

  // scoreboard
  logic [15:0] exp_q [$];
  string       tag_q [$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid === 1'b1) begin
      if (exp_q.size() == 0) check(1'b0, "R4", "unexpected response", rsp_rdata, 0);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string       t = tag_q.pop_front();
        check(rsp_rdata == e, t, "read data", rsp_rdata, e);
      end
    end
  end

  function automatic logic [15:0] expect_rd(input logic [15:0] a, input logic [1:0] m);
    logic [15:0] v;
    v = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
    return v & {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic issue(input bit wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m, input logic [4:0] len, input string tag);
    logic [15:0] v;
    req_write = wr; req_addr = a; req_wdata = d; req_bmask = m; req_len = len;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) begin
      v = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
      if (m[1]) v[15:8] = d[15:8];
      if (m[0]) v[7:0]  = d[7:0];
      shadow[int'(a)] = v;
    end else if (len != 0 && (int'(a[3:0]) + int'(len) <= 16)) begin
      for (int i = 0; i < int'(len); i++) begin
        exp_q.push_back(expect_rd({a[15:4], a[3:0] + 4'(i)}, m));
        tag_q.push_back(tag);
      end
    end
  endtask

  task automatic busy_cycles(output int n);
    n = 0;
    while (!req_ready) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; req_bmask = '0; req_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check({req_ready, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n,
           mem_dq_oe, rsp_valid, rsp_err} == 10'b11_0_1111_000, "R1", "idle outputs",
          {req_ready, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n,
           mem_dq_oe, rsp_valid, rsp_err}, 10'b1101111000);

    issue(1'b1, 16'h1230, 16'hA1B2, 2'b11, 5'd1, "R2");
    busy_cycles(n);
    check(n == WR_N, "R3", "write busy cycles", n, WR_N);
    issue(1'b1, 16'h1231, 16'hC3D4, 2'b11, 5'd1, "R2");
    issue(1'b1, 16'h1232, 16'h5566, 2'b01, 5'd1, "R2");
    issue(1'b1, 16'h1232, 16'hEEFF, 2'b10, 5'd1, "R2");
    for (int i = 0; i < 16; i++)
      issue(1'b1, 16'h12A0 + 16'(i), 16'h7000 + 16'(i * 16'h0111), 2'b11, 5'd1, "R2");

    issue(1'b0, 16'h1230, 16'h0, 2'b11, 5'd1, "R4");
    busy_cycles(n);
    check(n == RD_N + TA_N, "R8", "read busy incl. turnaround", n, RD_N + TA_N);
    issue(1'b0, 16'h1231, 16'h0, 2'b11, 5'd1, "R4");
    issue(1'b0, 16'h1232, 16'h0, 2'b11, 5'd1, "R2");
    issue(1'b0, 16'h1232, 16'h0, 2'b01, 5'd1, "R5");
    issue(1'b0, 16'h1232, 16'h0, 2'b10, 5'd1, "R5");
    issue(1'b0, 16'h1231, 16'h0, 2'b00, 5'd1, "R5");

    issue(1'b0, 16'h12A0, 16'h0, 2'b11, 5'd16, "R6");
    issue(1'b0, 16'h12A5, 16'h0, 2'b10, 5'd4, "R6");

    issue(1'b0, 16'h12AE, 16'h0, 2'b11, 5'd3, "R7");
    check(rsp_err === 1'b1 && mem_ce1_n === 1'b1, "R7", "cross-page refusal",
          {rsp_err, mem_ce1_n}, 2'b11);
    @(negedge clk);
    check(rsp_err === 1'b0, "R7", "error pulse width", rsp_err, 0);
    issue(1'b0, 16'h12A3, 16'h0, 2'b11, 5'd0, "R7");
    check(rsp_err === 1'b1, "R7", "zero-length refusal", rsp_err, 1);
    issue(1'b0, 16'h12AF, 16'h0, 2'b11, 5'd1, "R7");

    issue(1'b0, 16'h12A0, 16'h0, 2'b11, 5'd8, "R6");
    req_write = 1'b1; req_addr = 16'h12A3; req_wdata = 16'hDEAD;
    req_bmask = 2'b11; req_len = 5'd1; req_valid = 1'b1;
    check(req_ready === 1'b0, "R9", "ready low while busy", req_ready, 0);
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    issue(1'b0, 16'h12A3, 16'h0, 2'b11, 5'd1, "R9");

    issue(1'b1, 16'h12B0, 16'h4242, 2'b11, 5'd7, "R10");
    issue(1'b0, 16'h12B0, 16'h0, 2'b11, 5'd2, "R10");

    issue(1'b1, 16'hFFFF, 16'h1357, 2'b11, 5'd1, "R2");
    issue(1'b0, 16'hFFFF, 16'h0, 2'b11, 5'd1, "R4");

    while (!req_ready) @(negedge clk);
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R4", "responses outstanding", exp_q.size(), 0);
    check(proto_err == 0, "R8", "bus driven during read", proto_err, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule